// File: doc/BRIEF.md
# Disk Controller Bus Bridge

This block is an I/O-port slave on an 8-bit microprocessor bus that connects to a disk controller with an 8-bit, active-low handshake interface. It answers a window of four consecutive port addresses. The upper address bits of the window are set by a configuration input. Software uses three registers in that window to run the whole controller protocol by programmed I/O: a data register shared by both directions, a write-only control register and a read-only bus status register.

Software waits until the controller is not busy. It then sets the select bit, which raises the controller's select line and puts the adapter's ID on data line 0. When BUSY answers, software swaps select for data enable and moves command, data, status and message bytes one at a time as REQ, I/O and C/D direct. The adapter raises ACK by itself after every data-register access made while REQ is present. It keeps ACK until the controller withdraws REQ. Outbound bytes sit in a holding register. An inbound byte stays frozen for as long as ACK is up.

All controller pins are active low. Every register bit is active high. Controller inputs pass through one capture register before they reach the status register, the inbound latch or the ACK logic.

Top module: `disk_host_bridge`

## Requirements
- R1: Only addresses whose upper ADDR_W-2 bits equal `cfg_base` are decoded. Any other address leaves every register unchanged and keeps `bus_rd_valid` low and `bus_rdata` at 0.
- R2: A read is decoded only when `bus_dbin`, `bus_prw` and `bus_sinp` are all high. A write is decoded only when `bus_sout` is high and `bus_prw` is low. `bus_rd_valid` is high in exactly the cycles of a decoded read.
- R3: Writing offset 1 updates the control register, which resets to zero. Bit 6 is select and drives `ctl_sel_n` low. Bit 1 is data enable. The other six bits have no effect.
- R4: Reading offset 2 returns REQ in bit 7, I/O in bit 6 (1 = toward the controller), MSG in bit 5, C/D in bit 4 (1 = command/status), BUSY in bit 3 and zeros in bits 2..0. Each bit is the inverse of its pin as sampled at the previous clock edge.
- R5: A write to offset 0 loads the holding register. When data enable is set, select is clear and I/O is 1, all eight data pins are enabled and carry the inverse of the held byte.
- R6: While select is set, only data line 0 is enabled (`ctl_db_oe` = 8'h01) and it is driven low.
- R7: In every other case `ctl_db_oe` is 8'h00.
- R8: Reading offset 0 returns the inverse of the data pins as sampled at the previous edge. This byte stays frozen while ACK is asserted.
- R9: ACK (`ctl_ack_n` low) is asserted one edge after a data-register read or write made while sampled REQ is 1. Accesses to other offsets, and data accesses while REQ is 0, do not assert it.
- R10: ACK stays asserted while sampled REQ is 1 and is released on the edge after sampled REQ is 0. Further data accesses while ACK is pending do not extend it.
- R11: Reads of offsets 1 and 3 return 0. Writes to offsets 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W-2 | Upper address bits of the four-port window |
| bus_addr | input | ADDR_W | Port address |
| bus_dbin | input | 1 | Read data strobe |
| bus_prw | input | 1 | Read/write line, high = read |
| bus_sinp | input | 1 | Input-cycle status |
| bus_sout | input | 1 | Output-cycle status |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| bus_rd_valid | output | 1 | A decoded read is in progress |
| ctl_db_n_in | input | 8 | Controller data pins, received, active low |
| ctl_db_n_out | output | 8 | Controller data pins, driven, active low |
| ctl_db_oe | output | 8 | Per-bit output enable for the data pins |
| ctl_req_n | input | 1 | REQ from the controller, active low |
| ctl_io_n | input | 1 | I/O direction from the controller, active low |
| ctl_msg_n | input | 1 | MSG from the controller, active low |
| ctl_cd_n | input | 1 | Command/data from the controller, active low |
| ctl_busy_n | input | 1 | BUSY from the controller, active low |
| ctl_sel_n | output | 1 | Select to the controller, active low |
| ctl_ack_n | output | 1 | Acknowledge to the controller, active low |

## Verification
The assertions check these rules on every cycle:
- ACK rises only after a qualified data access with REQ present.
- ACK is held while REQ persists and drops once REQ goes away.
- The inbound latch does not move under ACK.
- A read never reports valid without all three input strobes.
- The low status bits stay zero.
- Select mode drives only line 0, and no line is driven outside the two drive modes.

Only the bench scenarios can show the rest:
- the exact status and data values read back, with their one-edge sampling delay;
- that foreign addresses and malformed strobes leave state untouched;
- that the six unused control bits are ignored;
- that a second access during a pending ACK neither re-triggers nor lengthens it.

// File: rtl/dhb_pkg.sv
package dhb_pkg;
  localparam int DW = 8;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam int CTRL_SEL_BIT = 6;
  localparam int CTRL_DEN_BIT = 1;

  typedef struct packed {
    logic req;
    logic io;
    logic msg;
    logic cd;
    logic busy;
  } ctl_stat_t;

  // Status register image: handshake lines in the top five bits.
  function automatic logic [DW-1:0] pack_status(input ctl_stat_t s);
    return {s.req, s.io, s.msg, s.cd, s.busy, 3'b000};
  endfunction

  // Active-low pin bundle to active-high status fields.
  function automatic ctl_stat_t pins_to_stat(input logic req_n, input logic io_n,
                                             input logic msg_n, input logic cd_n,
                                             input logic busy_n);
    ctl_stat_t s;
    s.req  = ~req_n;
    s.io   = ~io_n;
    s.msg  = ~msg_n;
    s.cd   = ~cd_n;
    s.busy = ~busy_n;
    return s;
  endfunction
endpackage

// File: rtl/dhb_port_decode.sv
module dhb_port_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-3:0] cfg_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dbin,
  input  logic              bus_prw,
  input  logic              bus_sinp,
  input  logic              bus_sout,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [1:0]        port_ofs
);
  localparam int BASE_W = ADDR_W - 2;

  logic win_match;

  assign win_match = (bus_addr[ADDR_W-1 -: BASE_W] == cfg_base);
  assign port_ofs  = bus_addr[1:0];
  assign rd_hit    = win_match && bus_dbin && bus_prw && bus_sinp;
  assign wr_hit    = win_match && bus_sout && !bus_prw;
endmodule

// File: rtl/dhb_pin_capture.sv
module dhb_pin_capture
  import dhb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ctl_db_n_in,
  input  logic          ctl_req_n,
  input  logic          ctl_io_n,
  input  logic          ctl_msg_n,
  input  logic          ctl_cd_n,
  input  logic          ctl_busy_n,
  input  logic          freeze,
  output ctl_stat_t     stat_q,
  output logic [DW-1:0] in_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      in_q   <= '0;
    end else begin
      stat_q <= pins_to_stat(ctl_req_n, ctl_io_n, ctl_msg_n, ctl_cd_n, ctl_busy_n);
      if (!freeze) in_q <= ~ctl_db_n_in;
    end
  end
endmodule

// File: rtl/dhb_ack_gen.sv
module dhb_ack_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_evt,
  input  logic req_s,
  output logic ack_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else if (ack_q) begin
      if (!req_s) ack_q <= 1'b0;
    end else if (xfer_evt) begin
      ack_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dhb_bus_drive.sv
module dhb_bus_drive
  import dhb_pkg::*;
(
  input  logic          sel,
  input  logic          den,
  input  logic          io_s,
  input  logic [DW-1:0] hold_q,
  output logic          drive_data,
  output logic [DW-1:0] ctl_db_oe,
  output logic [DW-1:0] ctl_db_n_out
);
  localparam logic [DW-1:0] ID_MASK = DW'(1);

  assign drive_data = den && io_s && !sel;

  always_comb begin
    if (drive_data) begin
      ctl_db_oe    = '1;
      ctl_db_n_out = ~hold_q;
    end else if (sel) begin
      ctl_db_oe    = ID_MASK;
      ctl_db_n_out = ~ID_MASK;
    end else begin
      ctl_db_oe    = '0;
      ctl_db_n_out = '1;
    end
  end
endmodule

// File: rtl/disk_host_bridge.sv
module disk_host_bridge
  import dhb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-3:0] cfg_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dbin,
  input  logic              bus_prw,
  input  logic              bus_sinp,
  input  logic              bus_sout,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rd_valid,
  input  logic [7:0]        ctl_db_n_in,
  output logic [7:0]        ctl_db_n_out,
  output logic [7:0]        ctl_db_oe,
  input  logic              ctl_req_n,
  input  logic              ctl_io_n,
  input  logic              ctl_msg_n,
  input  logic              ctl_cd_n,
  input  logic              ctl_busy_n,
  output logic              ctl_sel_n,
  output logic              ctl_ack_n
);
  logic          rd_hit, wr_hit;
  logic [1:0]    port_ofs;
  ctl_stat_t     stat_q;
  logic [DW-1:0] in_q;
  logic [DW-1:0] hold_q;
  logic          sel_q, den_q;
  logic          ack_q;
  logic          req_s;
  logic          xfer_evt;
  logic          drive_data;

  dhb_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cfg_base(cfg_base), .bus_addr(bus_addr), .bus_dbin(bus_dbin),
    .bus_prw(bus_prw), .bus_sinp(bus_sinp), .bus_sout(bus_sout),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .port_ofs(port_ofs)
  );

  dhb_pin_capture u_cap (
    .clk(clk), .rst_n(rst_n), .ctl_db_n_in(ctl_db_n_in),
    .ctl_req_n(ctl_req_n), .ctl_io_n(ctl_io_n), .ctl_msg_n(ctl_msg_n),
    .ctl_cd_n(ctl_cd_n), .ctl_busy_n(ctl_busy_n), .freeze(ack_q),
    .stat_q(stat_q), .in_q(in_q)
  );

  assign req_s    = stat_q.req;
  assign xfer_evt = (rd_hit || wr_hit) && (port_ofs == OFS_DATA) && req_s;

  dhb_ack_gen u_ack (
    .clk(clk), .rst_n(rst_n), .xfer_evt(xfer_evt), .req_s(req_s), .ack_q(ack_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      den_q  <= 1'b0;
      hold_q <= '0;
    end else if (wr_hit) begin
      if (port_ofs == OFS_CTRL) begin
        sel_q <= bus_wdata[CTRL_SEL_BIT];
        den_q <= bus_wdata[CTRL_DEN_BIT];
      end
      if (port_ofs == OFS_DATA) hold_q <= bus_wdata;
    end
  end

  dhb_bus_drive u_drv (
    .sel(sel_q), .den(den_q), .io_s(stat_q.io), .hold_q(hold_q),
    .drive_data(drive_data), .ctl_db_oe(ctl_db_oe), .ctl_db_n_out(ctl_db_n_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      unique case (port_ofs)
        OFS_DATA: bus_rdata = in_q;
        OFS_STAT: bus_rdata = pack_status(stat_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign bus_rd_valid = rd_hit;
  assign ctl_sel_n    = ~sel_q;
  assign ctl_ack_n    = ~ack_q;
endmodule

// File: rtl/disk_host_bridge_chk.sv
module disk_host_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd_valid,
  input logic       bus_dbin,
  input logic       bus_prw,
  input logic       bus_sinp,
  input logic [7:0] bus_rdata,
  input logic [1:0] port_ofs,
  input logic       ack_q,
  input logic       req_s,
  input logic       xfer_evt,
  input logic       ctl_sel_n,
  input logic [7:0] ctl_db_oe,
  input logic [7:0] ctl_db_n_out,
  input logic       drive_data,
  input logic [7:0] in_q
);
  AST_RD_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid |-> (bus_dbin && bus_prw && bus_sinp)); // R2
  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_valid && port_ofs == 2'd2) |-> (bus_rdata[2:0] == 3'b000)); // R4
  AST_SEL_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_sel_n |-> (ctl_db_oe == 8'h01 && !ctl_db_n_out[0])); // R6
  AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel_n && !drive_data) |-> (ctl_db_oe == 8'h00)); // R7
  AST_INBOUND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && $past(ack_q)) |-> $stable(in_q)); // R8
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(xfer_evt)); // R9
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req_s) |=> ack_q); // R10
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !req_s) |=> !ack_q); // R10
endmodule

bind disk_host_bridge disk_host_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd_valid(bus_rd_valid), .bus_dbin(bus_dbin),
  .bus_prw(bus_prw), .bus_sinp(bus_sinp), .bus_rdata(bus_rdata),
  .port_ofs(port_ofs), .ack_q(ack_q), .req_s(req_s), .xfer_evt(xfer_evt),
  .ctl_sel_n(ctl_sel_n), .ctl_db_oe(ctl_db_oe), .ctl_db_n_out(ctl_db_n_out),
  .drive_data(drive_data), .in_q(in_q)
);

// File: tb/disk_host_bridge_tb.sv
module disk_host_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_base = 6'h2C;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_dbin = 1'b0, bus_prw = 1'b1, bus_sinp = 1'b0, bus_sout = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rd_valid;
  logic [7:0] ctl_db_n_in = 8'hFF;
  logic [7:0] ctl_db_n_out, ctl_db_oe;
  logic       ctl_req_n = 1'b1, ctl_io_n = 1'b1, ctl_msg_n = 1'b1;
  logic       ctl_cd_n = 1'b1, ctl_busy_n = 1'b1;
  logic       ctl_sel_n, ctl_ack_n;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  localparam logic [7:0] BASE = 8'hB0; // cfg_base 6'h2C << 2

  always #2 clk = ~clk;

  disk_host_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .bus_addr(bus_addr),
    .bus_dbin(bus_dbin), .bus_prw(bus_prw), .bus_sinp(bus_sinp), .bus_sout(bus_sout),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_valid(bus_rd_valid),
    .ctl_db_n_in(ctl_db_n_in), .ctl_db_n_out(ctl_db_n_out), .ctl_db_oe(ctl_db_oe),
    .ctl_req_n(ctl_req_n), .ctl_io_n(ctl_io_n), .ctl_msg_n(ctl_msg_n),
    .ctl_cd_n(ctl_cd_n), .ctl_busy_n(ctl_busy_n), .ctl_sel_n(ctl_sel_n),
    .ctl_ack_n(ctl_ack_n)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%02h expected=%02h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_sel, m_den, m_ack;
  bit [7:0] m_hold, m_in;
  bit [4:0] m_stat; // {req, io, msg, cd, busy}, sampled one edge late

  function automatic bit in_window(input logic [7:0] a);
    return (a >> 2) == int'(cfg_base);
  endfunction

  function automatic bit is_rd();
    return in_window(bus_addr) && bus_dbin === 1'b1 && bus_prw === 1'b1 && bus_sinp === 1'b1;
  endfunction

  function automatic bit is_wr();
    return in_window(bus_addr) && bus_sout === 1'b1 && bus_prw === 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= 0; m_den <= 0; m_ack <= 0; m_hold <= 0; m_in <= 0; m_stat <= 0;
    end else begin
      m_stat <= {!ctl_req_n, !ctl_io_n, !ctl_msg_n, !ctl_cd_n, !ctl_busy_n};
      if (!m_ack) m_in <= ~ctl_db_n_in;
      if (is_wr() && bus_addr % 4 == 1) begin
        m_sel <= bus_wdata[6];
        m_den <= bus_wdata[1];
      end
      if (is_wr() && bus_addr % 4 == 0) m_hold <= bus_wdata;
      if (m_ack) begin
        if (!m_stat[4]) m_ack <= 0;
      end else if ((is_rd() || is_wr()) && bus_addr % 4 == 0 && m_stat[4]) begin
        m_ack <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0] e_rd, e_oe, e_out;
      e_rd = 8'h00;
      if (is_rd()) begin
        case (bus_addr % 4)
          0: e_rd = m_in;
          2: e_rd = {m_stat, 3'b000};
          default: e_rd = 8'h00;
        endcase
      end
      if (m_den && m_stat[3] && !m_sel) begin
        e_oe = 8'hFF; e_out = ~m_hold;
      end else if (m_sel) begin
        e_oe = 8'h01; e_out = 8'hFE;
      end else begin
        e_oe = 8'h00; e_out = 8'hFF;
      end
      chk(bus_rd_valid == is_rd(), "R2 rd_valid", {7'd0, bus_rd_valid}, {7'd0, is_rd()});
      chk(bus_rdata == e_rd, "R4/R8 rdata", bus_rdata, e_rd);
      chk(ctl_sel_n == !m_sel, "R3 sel_n", {7'd0, ctl_sel_n}, {7'd0, !m_sel});
      chk(ctl_ack_n == !m_ack, "R9/R10 ack_n", {7'd0, ctl_ack_n}, {7'd0, !m_ack});
      chk(ctl_db_oe == e_oe, "R5/R6/R7 oe", ctl_db_oe, e_oe);
      if (e_oe != 0) chk(ctl_db_n_out == e_out, "R5/R6 db_out", ctl_db_n_out, e_out);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    step(1);
    bus_addr = a; bus_wdata = d; bus_sout = 1'b1; bus_prw = 1'b0;
    step(1);
    bus_sout = 1'b0; bus_prw = 1'b1;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d, output logic v);
    step(1);
    bus_addr = a; bus_dbin = 1'b1; bus_prw = 1'b1; bus_sinp = 1'b1;
    @(negedge clk);
    d = bus_rdata; v = bus_rd_valid;
    step(1);
    bus_dbin = 1'b0; bus_sinp = 1'b0;
  endtask

  initial begin : watchdog
    while (!finished && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic v;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R3: reset state
    chk(ctl_sel_n && ctl_ack_n && ctl_db_oe == 0, "R3 reset state", ctl_db_oe, 8'h00);

    // R3/R6: select puts ID on line 0
    host_write(BASE + 1, 8'h40);
    chk(ctl_sel_n == 1'b0, "R3 select asserted", {7'd0, ctl_sel_n}, 8'h00);
    chk(ctl_db_oe == 8'h01 && ctl_db_n_out[0] == 1'b0, "R6 ID on line 0", ctl_db_oe, 8'h01);

    // R4: BUSY reflected one edge late
    ctl_busy_n = 1'b0;
    host_read(BASE + 2, d, v);
    chk(d == 8'h08, "R4 status busy only", d, 8'h08);

    // R5/R9/R10: outbound command byte
    host_write(BASE + 1, 8'h02);
    ctl_io_n = 1'b0; ctl_cd_n = 1'b0; ctl_req_n = 1'b0;
    host_write(BASE + 0, 8'hA5);
    chk(ctl_ack_n == 1'b0, "R9 ack after data write with req", {7'd0, ctl_ack_n}, 8'h00);
    chk(ctl_db_oe == 8'hFF && ctl_db_n_out == 8'h5A, "R5 held byte driven", ctl_db_n_out, 8'h5A);
    host_read(BASE + 2, d, v);
    chk(d == 8'hD8, "R4 status req/io/cd/busy", d, 8'hD8);
    host_write(BASE + 0, 8'h3C);
    chk(ctl_db_n_out == 8'hC3, "R5 second byte held", ctl_db_n_out, 8'hC3);
    ctl_req_n = 1'b1;
    step(1);
    chk(ctl_ack_n == 1'b0, "R10 ack held one edge after req drop", {7'd0, ctl_ack_n}, 8'h00);
    step(1);
    chk(ctl_ack_n == 1'b1, "R10 ack released", {7'd0, ctl_ack_n}, 8'h01);
    step(2);
    chk(ctl_ack_n == 1'b1, "R10 no second ack", {7'd0, ctl_ack_n}, 8'h01);

    // R8: inbound byte frozen under ack
    ctl_io_n = 1'b1; ctl_db_n_in = ~8'h5A; ctl_req_n = 1'b0;
    host_read(BASE + 0, d, v);
    chk(d == 8'h5A, "R8 inbound byte", d, 8'h5A);
    chk(ctl_ack_n == 1'b0, "R9 ack after data read with req", {7'd0, ctl_ack_n}, 8'h00);
    chk(ctl_db_oe == 8'h00, "R7 no drive while io inbound", ctl_db_oe, 8'h00);
    ctl_db_n_in = ~8'h11;
    step(2);
    host_read(BASE + 0, d, v);
    chk(d == 8'h5A, "R8 frozen under ack", d, 8'h5A);
    ctl_req_n = 1'b1;
    step(3);
    host_read(BASE + 0, d, v);
    chk(d == 8'h11, "R8 tracks after release", d, 8'h11);
    chk(ctl_ack_n == 1'b1, "R9 no ack without req", {7'd0, ctl_ack_n}, 8'h01);

    // R9: status access with req does not ack
    ctl_req_n = 1'b0;
    step(1);
    host_read(BASE + 2, d, v);
    chk(ctl_ack_n == 1'b1, "R9 status read no ack", {7'd0, ctl_ack_n}, 8'h01);
    ctl_req_n = 1'b1;
    step(2);

    // R1: foreign window
    host_write(8'h31, 8'h40);
    chk(ctl_sel_n == 1'b1, "R1 foreign write ignored", {7'd0, ctl_sel_n}, 8'h01);
    host_read(8'h32, d, v);
    chk(v == 1'b0 && d == 8'h00, "R1 foreign read silent", d, 8'h00);

    // R2: malformed strobes
    step(1);
    bus_addr = BASE + 2; bus_dbin = 1'b1; bus_prw = 1'b1; bus_sinp = 1'b0;
    @(negedge clk);
    chk(bus_rd_valid == 1'b0, "R2 read needs sinp", {7'd0, bus_rd_valid}, 8'h00);
    step(1);
    bus_dbin = 1'b0; bus_addr = BASE + 1; bus_wdata = 8'h40; bus_sout = 1'b1; bus_prw = 1'b1;
    step(1);
    bus_sout = 1'b0;
    chk(ctl_sel_n == 1'b1, "R2 write needs prw low", {7'd0, ctl_sel_n}, 8'h01);

    // R11: write-only and spare offsets
    host_read(BASE + 1, d, v);
    chk(v == 1'b1 && d == 8'h00, "R11 control reads zero", d, 8'h00);
    host_read(BASE + 3, d, v);
    chk(d == 8'h00, "R11 spare reads zero", d, 8'h00);
    host_write(BASE + 3, 8'h40);
    host_write(BASE + 2, 8'h40);
    chk(ctl_sel_n == 1'b1 && ctl_db_oe == 8'h00, "R11 writes to 2/3 ignored", ctl_db_oe, 8'h00);

    // R3/R7: unused control bits ignored
    ctl_io_n = 1'b0;
    host_write(BASE + 1, 8'hBD);
    step(1);
    chk(ctl_sel_n == 1'b1 && ctl_db_oe == 8'h00, "R3 unused bits ignored", ctl_db_oe, 8'h00);

    step(2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule